// File: doc/BRIEF.md
# Two-Port GPIO Block with Alternate-Function Override

This block gives software a small register view of two general-purpose I/O ports on a byte-wide register bus. The bus has an address, a write strobe, a read strobe and 8-bit write and read data. The wide port has four pins, each with its own output latch bit and direction bit. Any of these pins can be claimed by a pulse-width-modulator channel through a per-channel enable input. The narrow port has a single pin at bit 7. When the chip runs its external bus, that pin is claimed by the bus read/write strobe.

A claimed pin is driven by its alternate function, and its stored direction bit is left as it is. When the function lets go, the stored direction bit takes effect again in the same cycle. Pin inputs are resynchronised through two flops. A data-register read returns the synchronised level for pins that are inputs and the latch value for pins that are driving. Pad electronics, pull-ups and the PWM generator are outside the block.

Top module: `pin_override_gpio`

## Requirements
- R1: The four registers sit at consecutive addresses starting at BASE_ADDR (default 0x7C), in this order: wide-port data, wide-port direction, narrow-port data, narrow-port direction. Wide-port pin k uses bit k (k = 0..3), and the narrow pin uses bit 7. Reads and writes take effect only when the address matches. Any other address reads 0x00 and ignores writes, and `rd_data` is 0x00 whenever `rd_en` is low.
- R2: Bits 7:4 of both wide-port registers and bits 6:0 of both narrow-port registers always read zero, and writes to them have no effect.
- R3: A pin that is not claimed by its alternate function has its output enable equal to its stored direction bit (0 = input only, 1 = drive). When the pin drives, its output equals its latch bit.
- R4: While `pwm_en[k]` is 1, wide pin k has its output enable at 1 and its output equal to `pwm_wave[k]`, in the same cycle. The stored direction bit is not changed.
- R5: When `pwm_en[k]` falls, the output enable of pin k equals its stored direction bit in that same cycle.
- R6: While `ext_bus_mode` is 1, the narrow pin has its output enable at 1 and its output equal to `bus_rw`. Its direction register keeps and reads back its stored value, which is 0 after reset.
- R7: Reset (active-low, asynchronous) clears both direction registers and the synchronisers. With no alternate function active, every output enable is then 0. The data latches are not reset.
- R8: A data-register read returns, bit by bit, the latch value for a pin whose output enable is 1. For a pin whose output enable is 0, it returns the pin input level sampled two rising edges earlier.
- R9: A data-register write always loads the latch, even for pins that are inputs. The loaded value is driven once the pin becomes an output.
- R10: A direction write in the same cycle as an alternate-function enable change is stored normally. The override still wins at the pin while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, data returned combinationally |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| pwm_en | input | 4 | Per-channel PWM enable; bit k claims wide pin k |
| pwm_wave | input | 4 | PWM waveform for each channel |
| ext_bus_mode | input | 1 | Expanded/test bus mode; claims the narrow pin |
| bus_rw | input | 1 | Bus read/write strobe carried on the narrow pin |
| wide_pin_in | input | 4 | Wide-port pin input levels |
| wide_pin_out | output | 4 | Wide-port pin output levels |
| wide_pin_oe | output | 4 | Wide-port pin output enables |
| narrow_pin_in | input | 1 | Narrow pin input level |
| narrow_pin_out | output | 1 | Narrow pin output level |
| narrow_pin_oe | output | 1 | Narrow pin output enable |

## Verification
Two events can fall in the same cycle: a register write (to direction or data) and a change in an override enable (a PWM channel or the external bus mode). The directed part of the bench writes a direction register in the very cycle a PWM enable rises. It then checks that the pin follows the override while the direction readback shows the written value. A long randomised phase drives writes, reads and override enables independently on every clock, so such collisions happen often. Each cycle the outputs and read data are compared against a behavioural model that keeps stored state separate from pin control.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  // register slots relative to the base address; order is decoded behaviour
  localparam int REG_NUM     = 4;
  localparam int SLOT_W_DATA = 0;
  localparam int SLOT_W_DIR  = 1;
  localparam int SLOT_N_DATA = 2;
  localparam int SLOT_N_DIR  = 3;

  // output enable of one pin: alternate function wins over direction bit
  function automatic logic pin_drive(input logic dir_bit, input logic claim);
    return claim | dir_bit;
  endfunction

  // output level of one pin
  function automatic logic pin_level(input logic claim, input logic alt_val,
                                     input logic latch_bit);
    return claim ? alt_val : latch_bit;
  endfunction

  // data readback: driven pins show the latch, inputs show the synchronised pad
  function automatic logic readback_bit(input logic oe, input logic latch_bit,
                                        input logic sync_bit);
    return oe ? latch_bit : sync_bit;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

  // cycles since reset, saturating, used only to arm the latency check
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  // R8: synchronised value is the pad level from two edges earlier
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_ovr_pkg::*;
#(
  parameter int           ADDR_W    = 8,
  parameter logic [7:0]   BASE_ADDR = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [REG_NUM-1:0] wr_sel,
  output logic [REG_NUM-1:0] rd_sel
);

  logic [REG_NUM-1:0] hit;

  for (genvar k = 0; k < REG_NUM; k++) begin : g_slot
    assign hit[k]    = (addr == ADDR_W'(BASE_ADDR + k));
    assign wr_sel[k] = hit[k] & wr;
    assign rd_sel[k] = hit[k] & rd;
  end

  // R1: at most one register answers an access
  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel) && $onehot0(wr_sel));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LSB   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [7:0]       wdata,
  input  logic [WIDTH-1:0] claim,
  input  logic [WIDTH-1:0] alt_val,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [7:0]       data_rd,
  output logic [7:0]       dir_rd
);

  localparam logic [7:0] FIELD_MASK = 8'(((1 << WIDTH) - 1) << LSB);

  logic [WIDTH-1:0] wfield;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_field;

  // only the implemented bit positions reach the storage (R2)
  assign wfield = WIDTH'((wdata & FIELD_MASK) >> LSB);

  // output latch: no reset, loads on every data write (R9)
  always_ff @(posedge clk) begin
    if (wr_data) lat_q <= wfield;
  end

  // direction register: cleared by reset (R7), never touched by a claim (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wfield;
  end

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_oe[i]   = pin_drive(dir_q[i], claim[i]);
    assign pin_out[i]  = pin_level(claim[i], alt_val[i], lat_q[i]);
    assign rd_field[i] = readback_bit(pin_oe[i], lat_q[i], pin_sync[i]);
  end

  assign data_rd = 8'(rd_field) << LSB;
  assign dir_rd  = 8'(dir_q) << LSB;

  // R4: a claimed pin drives the alternate value
  a_r4_forced_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & claim) == claim) && ((pin_out & claim) == (alt_val & claim)));

  // R4 / R10: a claim change alone leaves the stored direction as it was
  a_r4_dir_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ((claim != $past(claim)) && !wr_dir) |=> (dir_q == $past(dir_q)));

  // R3 / R5: unclaimed pins follow the stored direction bit in the same cycle
  a_r5_follow_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~claim) == (dir_q & ~claim)));

  // R9: a data write loads the latch whatever the pin direction
  a_r9_latch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (lat_q == $past(wfield)));

endmodule

// File: rtl/pin_override_gpio.sv
module pin_override_gpio
  import gpio_ovr_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] BASE_ADDR = 8'h7C,
  parameter int         WIDE_PINS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  input  logic [WIDE_PINS-1:0] pwm_en,
  input  logic [WIDE_PINS-1:0] pwm_wave,
  input  logic                 ext_bus_mode,
  input  logic                 bus_rw,
  input  logic [WIDE_PINS-1:0] wide_pin_in,
  output logic [WIDE_PINS-1:0] wide_pin_out,
  output logic [WIDE_PINS-1:0] wide_pin_oe,
  input  logic                 narrow_pin_in,
  output logic                 narrow_pin_out,
  output logic                 narrow_pin_oe
);

  localparam int NARROW_LSB = 7;

  logic [REG_NUM-1:0] wr_sel;
  logic [REG_NUM-1:0] rd_sel;
  logic [7:0] w_data_rd, w_dir_rd, n_data_rd, n_dir_rd;

  gpio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wr     (wr_en),
    .rd     (rd_en),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  gpio_port #(.WIDTH(WIDE_PINS), .LSB(0)) u_wide (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_sel[SLOT_W_DATA]),
    .wr_dir  (wr_sel[SLOT_W_DIR]),
    .wdata   (wr_data),
    .claim   (pwm_en),
    .alt_val (pwm_wave),
    .pin_in  (wide_pin_in),
    .pin_out (wide_pin_out),
    .pin_oe  (wide_pin_oe),
    .data_rd (w_data_rd),
    .dir_rd  (w_dir_rd)
  );

  gpio_port #(.WIDTH(1), .LSB(NARROW_LSB)) u_narrow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_sel[SLOT_N_DATA]),
    .wr_dir  (wr_sel[SLOT_N_DIR]),
    .wdata   (wr_data),
    .claim   (ext_bus_mode),
    .alt_val (bus_rw),
    .pin_in  (narrow_pin_in),
    .pin_out (narrow_pin_out),
    .pin_oe  (narrow_pin_oe),
    .data_rd (n_data_rd),
    .dir_rd  (n_dir_rd)
  );

  // read mux: selects are one-hot or empty, so an OR tree is enough
  always_comb begin
    rd_data = '0;
    if (rd_sel[SLOT_W_DATA]) rd_data = rd_data | w_data_rd;
    if (rd_sel[SLOT_W_DIR])  rd_data = rd_data | w_dir_rd;
    if (rd_sel[SLOT_N_DATA]) rd_data = rd_data | n_data_rd;
    if (rd_sel[SLOT_N_DIR])  rd_data = rd_data | n_dir_rd;
  end

  // R1: the read bus is quiet when no read is requested
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 8'h00));

  // R2: unimplemented positions of both ports read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_sel[SLOT_W_DATA] || rd_sel[SLOT_W_DIR]) |-> (rd_data[7:WIDE_PINS] == '0)) and
    ((rd_sel[SLOT_N_DATA] || rd_sel[SLOT_N_DIR]) |-> (rd_data[6:0] == 7'd0)));

  // R6: bus mode always drives the narrow pin with the strobe
  a_r6_bus_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bus_mode |-> (narrow_pin_oe && (narrow_pin_out == bus_rw)));

endmodule

// File: tb/test_pin_override_gpio.sv
`timescale 1ns/1ps
module test_pin_override_gpio;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] pwm_en = 4'h0, pwm_wave = 4'h0;
  logic       ext_bus_mode = 1'b0, bus_rw = 1'b0;
  logic [3:0] wide_pin_in = 4'h0;
  logic [3:0] wide_pin_out, wide_pin_oe;
  logic       narrow_pin_in = 1'b0;
  logic       narrow_pin_out, narrow_pin_oe;

  always #10 clk = ~clk;

  pin_override_gpio i_pin_override_gpio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_en(pwm_en), .pwm_wave(pwm_wave),
    .ext_bus_mode(ext_bus_mode), .bus_rw(bus_rw), .wide_pin_in(wide_pin_in),
    .wide_pin_out(wide_pin_out), .wide_pin_oe(wide_pin_oe),
    .narrow_pin_in(narrow_pin_in), .narrow_pin_out(narrow_pin_out),
    .narrow_pin_oe(narrow_pin_oe)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit started  = 0;
  bit done     = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [3:0] m_wlat, m_wdir;
  bit       m_nlat, m_ndir;
  bit [4:0] pad_hist[$];   // {narrow, wide} pad samples, oldest first

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wdir = 4'h0;
      m_ndir = 1'b0;
      pad_hist.delete();
    end else begin
      if (wr_en) begin
        if (bus_addr == 8'h7C) m_wlat = wr_data[3:0];
        if (bus_addr == 8'h7D) m_wdir = wr_data[3:0];
        if (bus_addr == 8'h7E) m_nlat = wr_data[7];
        if (bus_addr == 8'h7F) m_ndir = wr_data[7];
      end
      pad_hist.push_back({narrow_pin_in, wide_pin_in});
      if (pad_hist.size() > 2) pad_hist.pop_front();
    end
  end

  function automatic bit [4:0] synced();
    return (pad_hist.size() == 2) ? pad_hist[0] : 5'd0;
  endfunction

  function automatic bit [7:0] model_read();
    bit [3:0] woe;
    bit       noe;
    bit [4:0] s;
    bit [7:0] v;
    woe = pwm_en | m_wdir;
    noe = ext_bus_mode | m_ndir;
    s   = synced();
    v   = 8'h00;
    if (rd_en) begin
      case (bus_addr)
        8'h7C: for (int i = 0; i < 4; i++) v[i] = woe[i] ? m_wlat[i] : s[i];
        8'h7D: v = {4'h0, m_wdir};
        8'h7E: v[7] = noe ? m_nlat : s[4];
        8'h7F: v[7] = m_ndir;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  // per-cycle comparison in the middle of the low phase
  always @(negedge clk) begin
    #5;
    if (started && !done) begin
      bit [3:0] woe, wout;
      bit       noe, nout;
      woe  = pwm_en | m_wdir;
      for (int i = 0; i < 4; i++) wout[i] = pwm_en[i] ? pwm_wave[i] : m_wlat[i];
      noe  = ext_bus_mode | m_ndir;
      nout = ext_bus_mode ? bus_rw : m_nlat;
      chk("R3 R4 R5 wide_pin_oe", {4'h0, wide_pin_oe}, {4'h0, woe});
      chk("R4 wide_pin_out", {4'h0, wide_pin_out & woe}, {4'h0, wout & woe});
      chk("R6 narrow_pin_oe", {7'h0, narrow_pin_oe}, {7'h0, noe});
      if (noe) chk("R6 narrow_pin_out", {7'h0, narrow_pin_out}, {7'h0, nout});
      chk("R1 R2 R8 rd_data", rd_data, model_read());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    rd_en = 0; wr_en = 1; bus_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr_en = 0; rd_en = 1; bus_addr = a;
    #5;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(posedge clk);
    started = 1;
    idle(3);
    rst_n = 1;
    idle(2);

    // R7: reset leaves every pin an input and directions clear
    #5;
    chk("R7 wide oe after reset", {4'h0, wide_pin_oe}, 8'h00);
    chk("R7 narrow oe after reset", {7'h0, narrow_pin_oe}, 8'h00);
    bus_read(8'h7D, 8'h00, "R7 wide dir reset");
    bus_read(8'h7F, 8'h00, "R7 narrow dir reset");

    // R9 / R2: latch loads while pins are inputs; upper bits dropped
    bus_write(8'h7C, 8'hFA);
    bus_write(8'h7E, 8'hFF);
    wide_pin_in = 4'b0110; narrow_pin_in = 1'b0;
    idle(3);
    bus_read(8'h7C, 8'h06, "R8 R2 wide data reads pads");
    bus_read(8'h7E, 8'h00, "R8 narrow data reads pad");

    // R3 / R2: direction write, upper nibble ignored
    bus_write(8'h7D, 8'hF5);
    bus_read(8'h7D, 8'h05, "R2 wide dir upper bits");
    chk("R3 wide oe from dir", {4'h0, wide_pin_oe}, 8'h05);
    chk("R3 wide out is latch", {4'h0, wide_pin_out & 4'b0101}, 8'h00);
    bus_read(8'h7C, 8'h02, "R8 mixed in/out readback");

    // R4: PWM claims pins 3 and 1
    @(negedge clk);
    rd_en = 0; pwm_en = 4'b1010; pwm_wave = 4'b1000;
    #5;
    chk("R4 claimed oe", {4'h0, wide_pin_oe}, 8'h0F);
    chk("R4 claimed out", {4'h0, wide_pin_out}, 8'h08);
    bus_read(8'h7D, 8'h05, "R4 dir unchanged by claim");
    bus_read(8'h7C, 8'h0A, "R8 claimed pins read latch");

    // R5: release restores the stored direction in the same cycle
    @(negedge clk);
    rd_en = 0; pwm_en = 4'b0000;
    #5;
    chk("R5 release oe", {4'h0, wide_pin_oe}, 8'h05);

    // R9: latch written while pin 1 is an input, then made an output
    bus_write(8'h7C, 8'h03);
    bus_write(8'h7D, 8'h0F);
    #5;
    chk("R9 latched value driven", {4'h0, wide_pin_out}, 8'h03);

    // R10: direction write collides with a claim
    @(negedge clk);
    pwm_en = 4'b0001; pwm_wave = 4'b0001; wr_en = 1; bus_addr = 8'h7D; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 0;
    #5;
    chk("R10 claim wins at pin", {4'h0, wide_pin_oe}, 8'h01);
    bus_read(8'h7D, 8'h00, "R10 collided dir write stored");
    @(negedge clk);
    rd_en = 0; pwm_en = 4'b0000;
    #5;
    chk("R10 after release", {4'h0, wide_pin_oe}, 8'h00);

    // R6: bus mode claims narrow pin
    @(negedge clk);
    ext_bus_mode = 1; bus_rw = 1;
    #5;
    chk("R6 strobe oe", {7'h0, narrow_pin_oe}, 8'h01);
    chk("R6 strobe high", {7'h0, narrow_pin_out}, 8'h01);
    @(negedge clk);
    bus_rw = 0;
    #5;
    chk("R6 strobe low", {7'h0, narrow_pin_out}, 8'h00);
    bus_read(8'h7F, 8'h00, "R6 narrow dir still zero");
    bus_write(8'h7F, 8'hFF);
    bus_read(8'h7F, 8'h80, "R2 narrow dir low bits");
    @(negedge clk);
    rd_en = 0; ext_bus_mode = 0;
    #5;
    chk("R3 narrow drives latch", {7'h0, narrow_pin_out}, 8'h01);
    bus_read(8'h7E, 8'h80, "R8 narrow output reads latch");
    bus_write(8'h7F, 8'h00);
    narrow_pin_in = 1;
    idle(3);
    bus_read(8'h7E, 8'h80, "R8 narrow input high");

    // R1: neighbouring addresses are dead
    bus_write(8'h7B, 8'hFF);
    bus_write(8'h80, 8'hFF);
    bus_read(8'h7B, 8'h00, "R1 below base");
    bus_read(8'h80, 8'h00, "R1 above range");
    bus_read(8'h7D, 8'h00, "R1 stray writes ignored");
    @(negedge clk);
    rd_en = 0; bus_addr = 8'h7D;
    #5;
    chk("R1 idle read bus", rd_data, 8'h00);

    // randomised phase: writes, reads and claims collide freely
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      bus_addr      = 8'h7A + 8'($urandom_range(0, 7));
      wr_en         = $urandom_range(0, 3) == 0;
      rd_en         = $urandom_range(0, 1) == 0;
      wr_data       = 8'($urandom);
      pwm_en        = 4'($urandom);
      pwm_wave      = 4'($urandom);
      ext_bus_mode  = $urandom_range(0, 3) == 0;
      bus_rw        = 1'($urandom);
      wide_pin_in   = 4'($urandom);
      narrow_pin_in = 1'($urandom);
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; pwm_en = 0; ext_bus_mode = 0;

    // R7: mid-run reset clears directions
    bus_write(8'h7D, 8'h0F);
    bus_write(8'h7F, 8'h80);
    @(negedge clk);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
    #5;
    chk("R7 wide oe after second reset", {4'h0, wide_pin_oe}, 8'h00);
    chk("R7 narrow oe after second reset", {7'h0, narrow_pin_oe}, 8'h00);
    bus_read(8'h7D, 8'h00, "R7 wide dir cleared");
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule